// File: doc/BRIEF.md
# Single-Capture Phase-Frequency Detector

This block compares one rising edge of a reference clock against one rising edge of a delayed clock under test and reports the gap between them as pulses. It is built from two resettable set flops: the reference edge sets `up` and the clock-under-test edge sets `dn`. Once both are high they stay high together for a fixed overlap window, then both clear on the same cycle. Because that overlap always appears, even edges that arrive together still produce a pair of short pulses. Small gaps are therefore never lost in a dead zone.

Unlike a free-running detector, this one captures a single edge pair for each arming. After the first release a sticky internal flag blocks any further set. The block stays quiet until the controller drops `arm` and raises it again. Holding `arm` low forces both outputs low and discards any capture in progress.

The clock under test is assumed to lag the reference, so `up` carries the whole measurement. `nup` is its complement and drives a downstream switch. Both clock inputs are sampled by the block clock, so every width is counted in block-clock cycles.

Top module: `oneshot_pfd`

## Requirements
- R1: A rising edge on `ref_in` that is first sampled at clock edge k sets `up` at edge k+1 (two-stage input sampling). A rising edge on `cut_in` sets `dn` with the same latency.
- R2: `nup` is always the inverse of `up`.
- R3: Once `up` and `dn` are both high, they stay high together for exactly OVL_CYC cycles (default 3), then both fall on the same edge.
- R4: If the `cut_in` edge lags the `ref_in` edge by D cycles, the `up` pulse is D+OVL_CYC cycles wide and the `dn` pulse is OVL_CYC cycles wide. With D=0 both pulses are OVL_CYC cycles wide.
- R5: While `arm` stays high after a release, later edges on either input produce no further pulse.
- R6: When `arm` is low at a clock edge, `up` and `dn` are low after that edge, and input edges during that time produce no pulse.
- R7: Dropping `arm` for at least one cycle and raising it again allows exactly one new capture.
- R8: While `rst_n` is low at a clock edge, `up` and `dn` are low after it and `nup` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; samples both inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | High enables one capture; low disables and re-arms |
| ref_in | input | 1 | Reference clock edge input |
| cut_in | input | 1 | Delayed clock-under-test edge input |
| up | output | 1 | Set by the reference edge |
| nup | output | 1 | Complement of `up` |
| dn | output | 1 | Set by the clock-under-test edge |

## Verification
The checker assumes that a new capture starts only after `arm` has been low, and that each input rises at most once inside a capture window. It also assumes the clock under test lags or coincides with the reference. The stimulus keeps to these assumptions: it drops `arm` before every measurement, raises `ref_in` first and raises `cut_in` D cycles later. It re-toggles the inputs only after the release, to show that they are ignored. Inputs change on the falling clock edge, so no sample is ambiguous.

// File: rtl/pfd_pkg.sv
// Shared types for the single-capture phase detector.
// Assumes nothing beyond two input channels: reference and clock under test.
package pfd_pkg;
    localparam int NUM_CH = 2;
    localparam int CH_REF = 0;
    localparam int CH_CUT = 1;

    typedef logic [NUM_CH-1:0] ch_vec_t;
endpackage

// File: rtl/pfd_edge_sync.sv
// Samples an asynchronous clock input through a short register chain
// and flags one cycle per rising edge.
// Assumes STAGES >= 2 and input high/low phases of at least one cycle.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sr;

    // Shift the input sample through the chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], din};
    end

    // A rise is a fresh high following an older low.
    assign rise = sr[STAGES-2] & ~sr[STAGES-1];
endmodule

// File: rtl/pfd_set_flop.sv
// Resettable set flop: one detector leg. Clear has priority over set.
// Assumes clr and set_en are synchronous to clk.
module pfd_set_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set_en,
    output logic q
);
    // Hold the leg until a clear arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= 1'b0;
        else if (set_en)   q <= 1'b1;
    end
endmodule

// File: rtl/pfd_overlap_timer.sv
// Times how long both legs stay high and issues the release pulse
// after OVL_CYC cycles of overlap.
// Assumes OVL_CYC >= 1.
module pfd_overlap_timer #(
    parameter int OVL_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic both,
    output logic release_o
);
    localparam int CW = $clog2(OVL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(OVL_CYC - 1);

    logic [CW-1:0] cnt;

    // Count overlap cycles; restart whenever the overlap ends.
    always_ff @(posedge clk) begin
        if (!rst_n || kill)  cnt <= '0;
        else if (!both)      cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign release_o = both && (cnt == LAST);
endmodule

// File: rtl/oneshot_pfd.sv
// Single-capture phase-frequency detector. The reference edge sets up,
// the clock-under-test edge sets dn, and both clear together after a
// fixed overlap. A sticky flag blocks any further capture until arm
// drops. Assumes the clock under test lags or matches the reference.
module oneshot_pfd
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OVL_CYC     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic ref_in,
    input  logic cut_in,
    output logic up,
    output logic nup,
    output logic dn
);
    ch_vec_t raw_in;
    ch_vec_t rise;
    ch_vec_t leg_q;
    logic    done_q;
    logic    both;
    logic    rel;
    logic    clr;

    assign raw_in[CH_REF] = ref_in;
    assign raw_in[CH_CUT] = cut_in;

    assign both = leg_q[CH_REF] & leg_q[CH_CUT];
    assign clr  = ~arm | rel;

    // One sampler and one set flop per input channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_leg
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[i]),
            .rise (rise[i])
        );
        pfd_set_flop u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .set_en(arm & ~done_q & rise[i]),
            .q     (leg_q[i])
        );
    end

    pfd_overlap_timer #(.OVL_CYC(OVL_CYC)) u_ovl (
        .clk      (clk),
        .rst_n    (rst_n),
        .kill     (~arm),
        .both     (both),
        .release_o(rel)
    );

    // Sticky capture flag: set on release, cleared while disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) done_q <= 1'b0;
        else if (rel)       done_q <= 1'b1;
    end

    assign up  = leg_q[CH_REF];
    assign nup = ~leg_q[CH_REF];
    assign dn  = leg_q[CH_CUT];
endmodule

// File: rtl/oneshot_pfd_checks.sv
// Temporal checks for oneshot_pfd, attached to it with bind.
// Assumes a new capture starts only after arm has been low.
module oneshot_pfd_checks #(
    parameter int OVL_CYC = 3
) (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic up,
    input logic nup,
    input logic dn,
    input logic done_q
);
    int ovl_run;

    // Length of the current overlap, counted before this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovl_run <= 0;
        else if (up && dn) ovl_run <= ovl_run + 1;
        else               ovl_run <= 0;
    end

    a_r3_overlap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |-> (ovl_run < OVL_CYC));

    a_r3_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(up) && $past(dn)) |-> $fell(dn));

    a_r5_no_second_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && arm) |=> !$rose(up) && !$rose(dn));

    a_r5_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(up) && $past(dn) && $past(arm)) |-> done_q);

    a_r6_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> (!up && !dn));

    a_r2_nup_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up) |-> $fell(nup));
endmodule

bind oneshot_pfd oneshot_pfd_checks #(.OVL_CYC(OVL_CYC)) u_checks (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .up    (up),
    .nup   (nup),
    .dn    (dn),
    .done_q(done_q)
);

// File: tb/sim_oneshot_pfd.sv
module sim_oneshot_pfd;
    localparam int OVL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0;
    logic ref_in = 1'b0;
    logic cut_in = 1'b0;
    logic up, nup, dn;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // behavioural model state
    bit m_up, m_dn, m_done;
    int m_cnt;
    bit r_hist[$];
    bit c_hist[$];

    // pulse monitor
    int up_pulses, dn_pulses, cur_up, cur_dn, last_up_w, last_dn_w;
    bit prev_up, prev_dn, saw_ovl;

    oneshot_pfd #(.SYNC_STAGES(2), .OVL_CYC(OVL)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm),
        .ref_in(ref_in), .cut_in(cut_in),
        .up(up), .nup(nup), .dn(dn)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model update at each edge, then compare and measure pulses.
    always begin
        @(posedge clk);
        begin
            bit rr, cr;
            rr = (r_hist.size() == 2) && r_hist[0] && !r_hist[1];
            cr = (c_hist.size() == 2) && c_hist[0] && !c_hist[1];
            if (!rst_n) begin
                m_up = 0; m_dn = 0; m_done = 0; m_cnt = 0;
                r_hist.delete(); c_hist.delete();
                r_hist.push_front(1'b0); c_hist.push_front(1'b0);
            end else if (!arm) begin
                m_up = 0; m_dn = 0; m_done = 0; m_cnt = 0;
            end else if (m_up && m_dn) begin
                if (m_cnt == OVL - 1) begin
                    m_up = 0; m_dn = 0; m_cnt = 0; m_done = 1;
                end else m_cnt++;
            end else begin
                m_cnt = 0;
                if (!m_done && rr) m_up = 1;
                if (!m_done && cr) m_dn = 1;
            end
            if (rst_n) begin
                r_hist.push_front(ref_in); c_hist.push_front(cut_in);
                if (r_hist.size() > 2) void'(r_hist.pop_back());
                if (c_hist.size() > 2) void'(c_hist.pop_back());
            end
        end
        #2;
        check(up == m_up, "R1/R3 up vs model", int'(up), int'(m_up));
        check(dn == m_dn, "R1/R3 dn vs model", int'(dn), int'(m_dn));
        check(nup == !up, "R2 nup inverse", int'(nup), int'(!up));
        if (up && !prev_up) up_pulses++;
        if (dn && !prev_dn) dn_pulses++;
        if (up) cur_up++; else if (prev_up) begin last_up_w = cur_up; cur_up = 0; end
        if (dn) cur_dn++; else if (prev_dn) begin last_dn_w = cur_dn; cur_dn = 0; end
        if (up && dn) saw_ovl = 1;
        prev_up = up; prev_dn = dn;
    end

    task automatic clr_mon();
        up_pulses = 0; dn_pulses = 0; cur_up = 0; cur_dn = 0;
        last_up_w = -1; last_dn_w = -1; saw_ovl = 0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One armed measurement with the clock under test lagging by d cycles.
    task automatic measure(input int d);
        arm = 0; ref_in = 0; cut_in = 0;
        tick(2);
        arm = 1;
        tick(3);
        clr_mon();
        ref_in = 1;
        if (d == 0) cut_in = 1;
        tick(1);
        check(up == 0, "R1 up not yet set", int'(up), 0);
        if (d == 1) cut_in = 1;
        tick(1);
        check(up == 1, "R1 up set after two samples", int'(up), 1);
        if (d >= 2) begin
            check(dn == 0, "R1 dn waits for lagging edge", int'(dn), 0);
            tick(d - 2);
            cut_in = 1;
        end
        tick(d + OVL + 6);
        check(up_pulses == 1, "R4 one up pulse", up_pulses, 1);
        check(last_up_w == d + OVL, "R4 up width", last_up_w, d + OVL);
        check(last_dn_w == OVL, "R3 dn width", last_dn_w, OVL);
        check(saw_ovl, "R3 overlap seen", int'(saw_ovl), 1);
        // later edges must be ignored while still armed
        ref_in = 0; cut_in = 0;
        tick(3);
        ref_in = 1;
        tick(2);
        cut_in = 1;
        tick(8);
        check(up_pulses == 1, "R5 no second up pulse", up_pulses, 1);
        check(dn_pulses == 1, "R5 no second dn pulse", dn_pulses, 1);
    endtask

    initial begin
        tick(3);
        check(up == 0 && dn == 0 && nup == 1, "R8 reset state", int'({up, nup, dn}), 3'b010);
        rst_n = 1;
        tick(2);

        measure(4);
        measure(0);
        measure(1);
        measure(9);

        // R6: disarm in the middle of a capture
        arm = 0; ref_in = 0; cut_in = 0;
        tick(2);
        arm = 1;
        tick(3);
        clr_mon();
        ref_in = 1;
        tick(3);
        check(up == 1, "R6 up set before disarm", int'(up), 1);
        arm = 0;
        tick(1);
        check(up == 0 && dn == 0, "R6 disarm clears", int'({up, dn}), 0);
        cut_in = 1;
        tick(3);
        ref_in = 0; cut_in = 0;
        tick(2);
        ref_in = 1; cut_in = 1;
        tick(6);
        check(dn_pulses == 0, "R6 edges ignored while disarmed", dn_pulses, 0);
        check(up_pulses == 1, "R6 no new up while disarmed", up_pulses, 1);

        // R7: re-arm gives exactly one new capture
        ref_in = 0; cut_in = 0;
        tick(3);
        arm = 1;
        tick(3);
        clr_mon();
        ref_in = 1;
        tick(2);
        cut_in = 1;
        tick(12);
        check(up_pulses == 1 && dn_pulses == 1, "R7 one capture after re-arm", up_pulses + dn_pulses, 2);

        // R8: reset in the middle of a pulse
        arm = 0; ref_in = 0; cut_in = 0;
        tick(2);
        arm = 1;
        tick(3);
        ref_in = 1;
        tick(3);
        rst_n = 0;
        tick(1);
        check(up == 0 && dn == 0 && nup == 1, "R8 reset mid pulse", int'({up, nup, dn}), 3'b010);
        rst_n = 1;
        tick(4);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule